// File: doc/BRIEF.md
# Grouped Data Reuse Shift Register

This block is an input register for a streaming accelerator. It packs a group of equal-width data values into one word and presents every slot in parallel to the datapath that consumes them. Slot `i` occupies bits `i*SLOT_W+SLOT_W-1 : i*SLOT_W` of the word.

The block supports sliding-window loops, where the next iteration still needs some of the values the current one used. A reuse strobe keeps the `KEEP` highest slots by shifting the whole word down by `(SLOTS-KEEP)*SLOT_W` bits, so those values land in the lowest slots. The vacated upper slots read as zero until software fills them. Software fills them through a narrow partial-load port, so data already held is never fetched again. A full-width load is also available for the first iteration of a loop.

The parameters must satisfy `SLOTS > KEEP >= 1`, and elaboration stops otherwise. With the defaults (8-bit slots, four slots, two kept) the word is 32 bits wide, the size of an integer variable.

Top module: `grp_reuse_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the word becomes all zeros.
- R2: A full load writes `full_data` to every slot. It takes precedence over any partial load or reuse strobe in the same cycle.
- R3: A reuse strobe without a full load moves old slots `SLOTS-KEEP .. SLOTS-1` into slots `0 .. KEEP-1`, in the same order. The word is shifted down by `(SLOTS-KEEP)*SLOT_W` bits.
- R4: A reuse strobe with neither a full nor a partial load leaves slots `KEEP .. SLOTS-1` at zero.
- R5: A partial load alone writes `part_data` slot `j` into word slot `KEEP+j`, and leaves slots `0 .. KEEP-1` unchanged. The `part_data` port is `(SLOTS-KEEP)*SLOT_W` bits wide.
- R6: When a reuse strobe and a partial load coincide without a full load, the shift is applied first and the partial data then fills the freed slots.
- R7: With no strobe asserted, the word holds its value.
- R8: `word_out` is registered. The effect of a strobe appears after the next rising edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| full_we | input | 1 | Full-word load strobe |
| full_data | input | SLOTS*SLOT_W | Data for a full-word load |
| part_we | input | 1 | Partial load strobe for the upper slots |
| part_data | input | (SLOTS-KEEP)*SLOT_W | Data for slots KEEP..SLOTS-1 |
| reuse_stb | input | 1 | Reuse shift strobe |
| word_out | output | SLOTS*SLOT_W | Parallel view of all slots |

## Verification
Every result of this block is due exactly one rising edge after the strobe that caused it. The bench drives strobes and data at the falling edge. It checks that `word_out` still holds its old value just after that drive, and checks the new value at the following falling edge, one full cycle after the drive. The sweep steps through all eight combinations of the three strobes many times with changing data, and an arithmetic model of the requirements gives the expected word at each step. The bound properties use a single `|=>` step to match this one-cycle latency.

// File: rtl/grp_reuse_pkg.sv
package grp_reuse_pkg;
  typedef enum logic [2:0] {
    OP_HOLD       = 3'd0,
    OP_FULL       = 3'd1,
    OP_SHIFT      = 3'd2,
    OP_FILL       = 3'd3,
    OP_SHIFT_FILL = 3'd4
  } reuse_op_e;
endpackage

// File: rtl/grp_op_decode.sv
module grp_op_decode
  import grp_reuse_pkg::*;
(
  input  logic      full_we,
  input  logic      part_we,
  input  logic      reuse_stb,
  output reuse_op_e op
);
  always_comb begin
    if (full_we)                    op = OP_FULL;
    else if (reuse_stb && part_we)  op = OP_SHIFT_FILL;
    else if (reuse_stb)             op = OP_SHIFT;
    else if (part_we)               op = OP_FILL;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/grp_shift_net.sv
module grp_shift_net #(
  parameter int SLOT_W = 8,
  parameter int SLOTS  = 4,
  parameter int KEEP   = 2
) (
  input  logic [SLOTS*SLOT_W-1:0] cur,
  output logic [SLOTS*SLOT_W-1:0] shifted
);
  localparam int DROP = SLOTS - KEEP;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < KEEP) begin : g_keep
      assign shifted[i*SLOT_W +: SLOT_W] = cur[(i+DROP)*SLOT_W +: SLOT_W];
    end else begin : g_free
      assign shifted[i*SLOT_W +: SLOT_W] = '0;
    end
  end
endmodule

// File: rtl/grp_slot_merge.sv
module grp_slot_merge
  import grp_reuse_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int SLOTS  = 4,
  parameter int KEEP   = 2
) (
  input  reuse_op_e                      op,
  input  logic [SLOTS*SLOT_W-1:0]        cur,
  input  logic [SLOTS*SLOT_W-1:0]        shifted,
  input  logic [SLOTS*SLOT_W-1:0]        full_data,
  input  logic [(SLOTS-KEEP)*SLOT_W-1:0] part_data,
  output logic [SLOTS*SLOT_W-1:0]        nxt
);
  logic use_full, use_shift, use_part;
  assign use_full  = (op == OP_FULL);
  assign use_shift = (op == OP_SHIFT) || (op == OP_SHIFT_FILL);
  assign use_part  = (op == OP_FILL)  || (op == OP_SHIFT_FILL);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < KEEP) begin : g_low
      assign nxt[i*SLOT_W +: SLOT_W] =
        use_full  ? full_data[i*SLOT_W +: SLOT_W] :
        use_shift ? shifted[i*SLOT_W +: SLOT_W]   :
                    cur[i*SLOT_W +: SLOT_W];
    end else begin : g_high
      assign nxt[i*SLOT_W +: SLOT_W] =
        use_full  ? full_data[i*SLOT_W +: SLOT_W]        :
        use_part  ? part_data[(i-KEEP)*SLOT_W +: SLOT_W] :
        use_shift ? shifted[i*SLOT_W +: SLOT_W]          :
                    cur[i*SLOT_W +: SLOT_W];
    end
  end
endmodule

// File: rtl/grp_reuse_reg.sv
module grp_reuse_reg
  import grp_reuse_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int SLOTS  = 4,
  parameter int KEEP   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          full_we,
  input  logic [SLOTS*SLOT_W-1:0]        full_data,
  input  logic                          part_we,
  input  logic [(SLOTS-KEEP)*SLOT_W-1:0] part_data,
  input  logic                          reuse_stb,
  output logic [SLOTS*SLOT_W-1:0]        word_out
);
  localparam int WORD_W = SLOTS * SLOT_W;

  if (SLOTS <= KEEP || KEEP < 1) begin : g_bad_cfg
    $error("grp_reuse_reg: need SLOTS > KEEP >= 1");
  end

  reuse_op_e         op;
  logic [WORD_W-1:0] word_q, shifted, nxt;

  grp_op_decode u_dec (
    .full_we   (full_we),
    .part_we   (part_we),
    .reuse_stb (reuse_stb),
    .op        (op)
  );

  grp_shift_net #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .KEEP(KEEP)) u_shift (
    .cur     (word_q),
    .shifted (shifted)
  );

  grp_slot_merge #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .KEEP(KEEP)) u_merge (
    .op        (op),
    .cur       (word_q),
    .shifted   (shifted),
    .full_data (full_data),
    .part_data (part_data),
    .nxt       (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)                 word_q <= '0;
    else if (op != OP_HOLD)  word_q <= nxt;
  end

  assign word_out = word_q;
endmodule

// File: rtl/grp_reuse_chk.sv
module grp_reuse_chk #(
  parameter int SLOT_W = 8,
  parameter int SLOTS  = 4,
  parameter int KEEP   = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          full_we,
  input logic [SLOTS*SLOT_W-1:0]        full_data,
  input logic                          part_we,
  input logic [(SLOTS-KEEP)*SLOT_W-1:0] part_data,
  input logic                          reuse_stb,
  input logic [SLOTS*SLOT_W-1:0]        word_out
);
  localparam int WORD_W = SLOTS * SLOT_W;
  localparam int LOW_W  = KEEP * SLOT_W;
  localparam int HIGH_W = WORD_W - LOW_W;

  logic [LOW_W-1:0]  low_now, top_now;
  logic [HIGH_W-1:0] high_now;
  assign low_now  = word_out[LOW_W-1:0];
  assign high_now = word_out[WORD_W-1:LOW_W];
  assign top_now  = word_out[WORD_W-1:WORD_W-LOW_W];

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
    full_we |=> word_out == $past(full_data)); // R2
  AST_KEEP_MOVE: assert property (@(posedge clk) disable iff (rst)
    (reuse_stb && !full_we) |=> low_now == $past(top_now)); // R3
  AST_FREED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reuse_stb && !full_we && !part_we) |=> high_now == '0); // R4
  AST_PART_LOW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (part_we && !full_we && !reuse_stb) |=> $stable(low_now)); // R5
  AST_PART_FILL: assert property (@(posedge clk) disable iff (rst)
    (part_we && !full_we) |=> high_now == $past(part_data)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!full_we && !part_we && !reuse_stb) |=> $stable(word_out)); // R7
endmodule

bind grp_reuse_reg grp_reuse_chk #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .KEEP(KEEP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .full_we   (full_we),
  .full_data (full_data),
  .part_we   (part_we),
  .part_data (part_data),
  .reuse_stb (reuse_stb),
  .word_out  (word_out)
);

// File: tb/grp_reuse_reg_test.sv
`timescale 1ns/1ps
module grp_reuse_reg_test;
  localparam int SW = 8;
  localparam int G  = 4;
  localparam int P  = 2;
  localparam int WW = G * SW;
  localparam int PW = (G - P) * SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          full_we = 1'b0, part_we = 1'b0, reuse_stb = 1'b0;
  logic [WW-1:0] full_data = '0;
  logic [PW-1:0] part_data = '0;
  logic [WW-1:0] word_out;

  int checks = 0;
  int fails  = 0;
  logic [WW-1:0] model;

  always #2.5 clk = ~clk;

  grp_reuse_reg #(.SLOT_W(SW), .SLOTS(G), .KEEP(P)) uut (
    .clk(clk), .rst(rst), .full_we(full_we), .full_data(full_data),
    .part_we(part_we), .part_data(part_data), .reuse_stb(reuse_stb),
    .word_out(word_out)
  );

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected word from the requirements: full load wins (R2); the reuse
  // shift moves the word down by (G-P)*SW bits, zero filling (R3, R4);
  // the partial load then writes the upper slots (R5, R6).
  function automatic logic [WW-1:0] expect_next(
    input logic [WW-1:0] old, input logic f, input logic [WW-1:0] fd,
    input logic pw, input logic [PW-1:0] pd, input logic r);
    logic [WW-1:0] t;
    if (f) return fd;
    t = old;
    if (r)  t = old >> PW;
    if (pw) t[WW-1:P*SW] = pd;
    return t;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", word_out, '0);
    rst = 1'b0;
    model = '0;
    for (int it = 0; it < 48; it++) begin
      for (int c = 0; c < 8; c++) begin
        logic [WW-1:0] exp;
        @(negedge clk);
        full_we   = c[0];
        part_we   = c[1];
        reuse_stb = c[2];
        full_data = WW'((it * 8 + c + 1) * 32'h9E3779B1);
        part_data = PW'((it * 8 + c + 3) * 32'h7F4A7C15);
        exp = expect_next(model, c[0], full_data, c[1], part_data, c[2]);
        #1;
        check("R8 no early change", word_out, model);
        @(negedge clk);
        full_we = 1'b0; part_we = 1'b0; reuse_stb = 1'b0;
        if (c[0])             check("R2 full load", word_out, exp);
        else if (c[2] && c[1]) check("R6 shift then fill", word_out, exp);
        else if (c[2]) begin
          check("R3 kept slots", {{PW{1'b0}}, word_out[P*SW-1:0]}, {{PW{1'b0}}, exp[P*SW-1:0]});
          check("R4 freed slots zero", {word_out[WW-1:P*SW], {(P*SW){1'b0}}}, {exp[WW-1:P*SW], {(P*SW){1'b0}}});
        end
        else if (c[1])         check("R5 partial fill", word_out, exp);
        else                   check("R7 hold", word_out, exp);
        model = exp;
      end
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after use", word_out, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule